// File: doc/BRIEF.md
# Command Mailbox Between Fabric Engine and Microcontroller

This block is a shared mailbox. A command engine in programmable logic uses it to pass a request to a small soft-core microcontroller and to learn when that request has been served. The engine side writes the request payload byte by byte into a 2 KiB shared buffer. It then pulses a request strobe, which loads the operation code, the locality and the payload length and sets an execute flag. While that flag is set, a level-sensitive, active-high interrupt tells the microcontroller that work is waiting.

The microcontroller sees a 4 KiB window on a single-cycle 32-bit register bus. The window holds read-only request registers, a write-only completion register and the shared buffer at offsets 0x800 to 0xFFF. Any offset that is not mapped reads back the marker word 0xBADFABAC, and writes to such offsets are discarded. A write of any data to the completion register starts a fixed-length completion pulse toward the engine. When that pulse ends, the execute flag, the abort flag and the operation code are cleared. The engine can then read the response from the buffer.

Top module: `mbox_bridge`

## Requirements
- R1: After reset, the execute, abort and completion indications are low, the interrupt is low, and the status word and operation code read as 0.
- R2: A microcontroller read of any window offset below 0x800 other than 0x000, 0x004, 0x008 and 0x00C returns 0xBADFABAC. This includes the completion register at 0x040. Writes to unmapped offsets change nothing that can be read back.
- R3: Microcontroller writes to the four request registers at 0x000 to 0x00C are discarded.
- R4: The request strobe, when the execute flag is clear, sets execute and loads the operation code, locality and length in the same cycle. Status word at 0x000 uses bit 0 = execute, bit 1 = abort and bit 2 = completion. Offset 0x004 returns the operation code in bits 3:0, 0x008 the locality in bits 3:0 and 0x00C the length in bits 11:0. All other bits read 0. A request strobe while execute is set is ignored.
- R5: The interrupt is high exactly while execute is set and no completion pulse is running.
- R6: A write of any data to offset 0x040, made when no completion pulse is running, drives the completion output high for exactly 4 consecutive cycles, starting in the cycle after the write. A further write during the pulse does not extend it.
- R7: In the cycle in which the completion output falls, execute, abort and the operation code become 0. Locality and length keep their values.
- R8: The abort strobe sets status bit 1 while execute is set. It is ignored while execute is clear.
- R9: Offsets 0x800 to 0xFFF map the shared buffer as 32-bit words, with byte lane k holding buffer byte 4*word+k. While execute is set, microcontroller writes update only the lanes whose byte strobe is high. While execute is clear, microcontroller writes to the buffer are dropped.
- R10: The engine's byte port writes any buffer byte regardless of execute and returns the addressed byte in the following cycle. If both sides write the same byte in one cycle, the microcontroller's data is kept.
- R11: Microcontroller read data is valid in the cycle after the request. Address bits 1:0 are ignored by the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreq_i | input | 1 | Microcontroller bus request |
| mwe_i | input | 1 | Microcontroller write enable |
| mbe_i | input | 4 | Microcontroller byte strobes |
| maddr_i | input | 12 | Microcontroller byte offset in the window |
| mwdata_i | input | 32 | Microcontroller write data |
| mrdata_o | output | 32 | Microcontroller read data, valid one cycle after a read |
| irq_o | output | 1 | Interrupt toward the microcontroller, level, active high |
| req_i | input | 1 | Engine request strobe |
| op_i | input | OP_W | Operation code loaded by the request |
| loc_i | input | LOC_W | Locality loaded by the request (0xF = none active) |
| size_i | input | SIZE_W | Payload length in bytes loaded by the request |
| abort_i | input | 1 | Engine abort strobe |
| done_o | output | 1 | Completion pulse toward the engine |
| fb_addr_i | input | BAW+2 | Engine byte address into the buffer |
| fb_we_i | input | 1 | Engine byte write enable |
| fb_wdata_i | input | 8 | Engine write byte |
| fb_rdata_o | output | 8 | Engine read byte, one cycle after the address |

## Verification
The bench builds the block with its default parameters: a 4-cycle completion pulse, 4-bit operation and locality fields, a 12-bit length and a 512-word buffer that fills the upper half of the window. The short pulse lets the bench place a repeated completion write inside a running pulse. It also lets the bench time the falling edge of execute against the completion output. With the full-size buffer, the bench reaches buffer bytes at both ends of the upper window half through word addresses. It also drives a same-byte write from both sides in one cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int          WIN_AW    = 12;
  localparam logic [31:0] BAD_WORD  = 32'hBADFABAC;
  localparam logic [11:0] OFF_STAT  = 12'h000;
  localparam logic [11:0] OFF_OP    = 12'h004;
  localparam logic [11:0] OFF_LOC   = 12'h008;
  localparam logic [11:0] OFF_SIZE  = 12'h00C;
  localparam logic [11:0] OFF_DONE  = 12'h040;

  typedef enum logic [2:0] {
    SEL_STAT,
    SEL_OP,
    SEL_LOC,
    SEL_SIZE,
    SEL_DONE,
    SEL_BUF,
    SEL_NONE
  } sel_e;

  // Map a window byte offset to a target; bits 1:0 do not take part.
  function automatic sel_e decode_off(input logic [WIN_AW-1:0] a);
    logic [WIN_AW-1:0] w;
    w = {a[WIN_AW-1:2], 2'b00};
    if (a[WIN_AW-1]) return SEL_BUF;
    case (w)
      OFF_STAT: return SEL_STAT;
      OFF_OP:   return SEL_OP;
      OFF_LOC:  return SEL_LOC;
      OFF_SIZE: return SEL_SIZE;
      OFF_DONE: return SEL_DONE;
      default:  return SEL_NONE;
    endcase
  endfunction

  // Status word layout: bit0 execute, bit1 abort, bit2 completion.
  function automatic logic [31:0] status_word(input logic ex, input logic ab,
                                              input logic dn);
    return {29'd0, dn, ab, ex};
  endfunction

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl #(
  parameter int OP_W      = 4,
  parameter int LOC_W     = 4,
  parameter int SIZE_W    = 12,
  parameter int PULSE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              abort_i,
  input  logic              cmpl_wr_i,
  output logic              exec_o,
  output logic              abort_o,
  output logic [OP_W-1:0]   op_o,
  output logic [LOC_W-1:0]  loc_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              done_o,
  output logic              done_end_o,
  output logic              irq_o
);

  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          accept;

  assign done_o     = (cnt_q != '0);
  assign done_end_o = (cnt_q == CW'(1));
  assign accept     = req_i && !exec_o && !done_end_o;
  assign irq_o      = exec_o && !done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (done_o) begin
      cnt_q <= cnt_q - CW'(1);
    end else if (cmpl_wr_i) begin
      cnt_q <= CW'(PULSE_CYC);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_o  <= 1'b0;
      abort_o <= 1'b0;
      op_o    <= '0;
      loc_o   <= '0;
      size_o  <= '0;
    end else if (done_end_o) begin
      exec_o  <= 1'b0;
      abort_o <= 1'b0;
      op_o    <= '0;
    end else if (accept) begin
      exec_o  <= 1'b1;
      abort_o <= 1'b0;
      op_o    <= op_i;
      loc_o   <= loc_i;
      size_o  <= size_i;
    end else if (abort_i && exec_o) begin
      abort_o <= 1'b1;
    end
  end

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int LOC_W  = 4,
  parameter int SIZE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mreq_i,
  input  logic              mwe_i,
  input  logic [WIN_AW-1:0] maddr_i,
  input  logic              exec_i,
  input  logic              abort_i,
  input  logic              done_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              cmpl_wr_o,
  output logic              buf_we_o,
  output logic              buf_re_o,
  output logic              rd_unmapped_o,
  output logic [31:0]       reg_rdata_o,
  output logic              sel_buf_o
);

  sel_e        sel;
  logic        rd, wr;
  logic [31:0] word;

  assign sel           = decode_off(maddr_i);
  assign rd            = mreq_i && !mwe_i;
  assign wr            = mreq_i && mwe_i;
  assign cmpl_wr_o     = wr && (sel == SEL_DONE);
  assign buf_we_o      = wr && (sel == SEL_BUF) && exec_i;
  assign buf_re_o      = rd && (sel == SEL_BUF);
  assign rd_unmapped_o = rd && ((sel == SEL_NONE) || (sel == SEL_DONE));

  always_comb begin
    case (sel)
      SEL_STAT: word = status_word(exec_i, abort_i, done_i);
      SEL_OP:   word = {{(32-OP_W){1'b0}}, op_i};
      SEL_LOC:  word = {{(32-LOC_W){1'b0}}, loc_i};
      SEL_SIZE: word = {{(32-SIZE_W){1'b0}}, size_i};
      default:  word = BAD_WORD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_o <= '0;
      sel_buf_o   <= 1'b0;
    end else if (rd) begin
      reg_rdata_o <= word;
      sel_buf_o   <= (sel == SEL_BUF);
    end
  end

endmodule

// File: rtl/mbox_buf.sv
module mbox_buf #(
  parameter int WORDS = 512
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 a_re_i,
  input  logic                 a_we_i,
  input  logic [3:0]           a_be_i,
  input  logic [$clog2(WORDS)-1:0] a_addr_i,
  input  logic [31:0]          a_wdata_i,
  output logic [31:0]          a_rdata_o,
  input  logic [$clog2(WORDS)+1:0] b_addr_i,
  input  logic                 b_we_i,
  input  logic [7:0]           b_wdata_i,
  output logic [7:0]           b_rdata_o
);

  localparam int AW = $clog2(WORDS);

  logic [AW-1:0] b_word;
  logic [1:0]    b_lane, b_lane_q;
  logic [7:0]    b_lane_rd [4];

  assign b_word = b_addr_i[AW+1:2];
  assign b_lane = b_addr_i[1:0];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] a_q, b_q;
    // Engine write first, microcontroller write last so it wins a collision.
    always_ff @(posedge clk_i) begin
      if (b_we_i && (b_lane == 2'(g))) mem[b_word] <= b_wdata_i;
      if (a_we_i && a_be_i[g])         mem[a_addr_i] <= a_wdata_i[8*g +: 8];
      if (a_re_i)                      a_q <= mem[a_addr_i];
      b_q <= mem[b_word];
    end
    assign a_rdata_o[8*g +: 8] = a_q;
    assign b_lane_rd[g]        = b_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) b_lane_q <= '0;
    else         b_lane_q <= b_lane;
  end

  assign b_rdata_o = b_lane_rd[b_lane_q];

endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int OP_W      = 4,
  parameter int LOC_W     = 4,
  parameter int SIZE_W    = 12,
  parameter int PULSE_CYC = 4,
  parameter int BUF_WORDS = 512,
  localparam int BAW      = $clog2(BUF_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mreq_i,
  input  logic              mwe_i,
  input  logic [3:0]        mbe_i,
  input  logic [11:0]       maddr_i,
  input  logic [31:0]       mwdata_i,
  output logic [31:0]       mrdata_o,
  output logic              irq_o,
  input  logic              req_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              abort_i,
  output logic              done_o,
  input  logic [BAW+1:0]    fb_addr_i,
  input  logic              fb_we_i,
  input  logic [7:0]        fb_wdata_i,
  output logic [7:0]        fb_rdata_o
);

  logic              exec_q, abort_q, done_end;
  logic [OP_W-1:0]   op_q;
  logic [LOC_W-1:0]  loc_q;
  logic [SIZE_W-1:0] size_q;
  logic              cmpl_wr, buf_we, buf_re, rd_unmapped, sel_buf_q;
  logic [31:0]       reg_rdata_q, buf_rdata;

  mbox_ctrl #(
    .OP_W(OP_W), .LOC_W(LOC_W), .SIZE_W(SIZE_W), .PULSE_CYC(PULSE_CYC)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i), .loc_i(loc_i),
    .size_i(size_i), .abort_i(abort_i), .cmpl_wr_i(cmpl_wr), .exec_o(exec_q),
    .abort_o(abort_q), .op_o(op_q), .loc_o(loc_q), .size_o(size_q),
    .done_o(done_o), .done_end_o(done_end), .irq_o(irq_o)
  );

  mbox_regs #(
    .OP_W(OP_W), .LOC_W(LOC_W), .SIZE_W(SIZE_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .mreq_i(mreq_i), .mwe_i(mwe_i),
    .maddr_i(maddr_i), .exec_i(exec_q), .abort_i(abort_q), .done_i(done_o),
    .op_i(op_q), .loc_i(loc_q), .size_i(size_q), .cmpl_wr_o(cmpl_wr),
    .buf_we_o(buf_we), .buf_re_o(buf_re), .rd_unmapped_o(rd_unmapped),
    .reg_rdata_o(reg_rdata_q), .sel_buf_o(sel_buf_q)
  );

  mbox_buf #(
    .WORDS(BUF_WORDS)
  ) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_re_i(buf_re), .a_we_i(buf_we),
    .a_be_i(mbe_i), .a_addr_i(maddr_i[BAW+1:2]), .a_wdata_i(mwdata_i),
    .a_rdata_o(buf_rdata), .b_addr_i(fb_addr_i), .b_we_i(fb_we_i),
    .b_wdata_i(fb_wdata_i), .b_rdata_o(fb_rdata_o)
  );

  assign mrdata_o = sel_buf_q ? buf_rdata : reg_rdata_q;

endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk
  import mbox_pkg::*;
#(
  parameter int OP_W      = 4,
  parameter int PULSE_CYC = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            exec_q,
  input logic            done_o,
  input logic            done_end,
  input logic            cmpl_wr,
  input logic            irq_o,
  input logic [OP_W-1:0] op_q,
  input logic            rd_unmapped,
  input logic [31:0]     mrdata_o
);

  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (done_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  // R6
  pulse_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> run_q < PULSE_CYC);

  // R6
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> run_q == PULSE_CYC);

  // R6
  pulse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cmpl_wr));

  // R5
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (exec_q && !done_o));

  // R7
  exec_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(exec_q) |-> ($fell(done_o) && op_q == '0));

  // R2
  bad_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_unmapped) |-> mrdata_o == BAD_WORD);

  // R4
  req_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && !exec_q && !done_end) |-> exec_q);

endmodule

bind mbox_bridge mbox_bridge_chk #(.OP_W(OP_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .exec_q(exec_q),
  .done_o(done_o), .done_end(done_end), .cmpl_wr(cmpl_wr), .irq_o(irq_o),
  .op_q(op_q), .rd_unmapped(rd_unmapped), .mrdata_o(mrdata_o)
);

// File: tb/tb_mbox_bridge.sv
module tb_mbox_bridge;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MAGIC = 32'hBADFABAC;

  logic        clk, rst_n;
  logic        mreq, mwe;
  logic [3:0]  mbe;
  logic [11:0] maddr;
  logic [31:0] mwdata, mrdata;
  logic        irq, req, abrt, done;
  logic [3:0]  op, loc;
  logic [11:0] size;
  logic [10:0] fb_addr;
  logic        fb_we;
  logic [7:0]  fb_wdata, fb_rdata;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string rd_tag = "R11";

  mbox_bridge dut (
    .clk_i(clk), .rst_ni(rst_n), .mreq_i(mreq), .mwe_i(mwe), .mbe_i(mbe),
    .maddr_i(maddr), .mwdata_i(mwdata), .mrdata_o(mrdata), .irq_o(irq),
    .req_i(req), .op_i(op), .loc_i(loc), .size_i(size), .abort_i(abrt),
    .done_o(done), .fb_addr_i(fb_addr), .fb_we_i(fb_we),
    .fb_wdata_i(fb_wdata), .fb_rdata_o(fb_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0]  rmem [0:2047];
  bit          rknown [0:2047];
  bit          m_exec, m_abort;
  int          m_op, m_loc, m_size, m_cnt;
  bit          rd_pend, fb_pend, exp_done, exp_irq;
  logic [31:0] exp_rd;
  logic [7:0]  exp_fb;
  string       exp_tag;
  int          off, base;
  bit          cw, end_now;

  initial begin
    for (int i = 0; i < 2048; i++) rknown[i] = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_exec = 0; m_abort = 0; m_op = 0; m_loc = 0; m_size = 0; m_cnt = 0;
      rd_pend = 0; fb_pend = 0;
    end else begin
      rd_pend = 0;
      fb_pend = 0;
      off = int'(maddr) & 32'hFFC;
      if (mreq && !mwe) begin
        rd_pend = 1;
        exp_tag = rd_tag;
        if (maddr[11]) begin
          base = int'(maddr[10:0]) & 32'h7FC;
          if (m_exec && rknown[base] && rknown[base+1] && rknown[base+2] && rknown[base+3])
            exp_rd = {rmem[base+3], rmem[base+2], rmem[base+1], rmem[base]};
          else
            rd_pend = 0;
        end else if (off == 0)   exp_rd = {29'd0, m_cnt != 0, m_abort, m_exec};
        else if (off == 4)       exp_rd = m_op;
        else if (off == 8)       exp_rd = m_loc;
        else if (off == 12)      exp_rd = m_size;
        else                     exp_rd = MAGIC;
      end
      if (rknown[fb_addr]) begin
        fb_pend = 1;
        exp_fb = rmem[fb_addr];
      end
      if (fb_we) begin
        rmem[fb_addr] = fb_wdata;
        rknown[fb_addr] = 1;
      end
      if (mreq && mwe && maddr[11] && m_exec) begin
        base = int'(maddr[10:0]) & 32'h7FC;
        for (int k = 0; k < 4; k++)
          if (mbe[k]) begin
            rmem[base+k] = mwdata[8*k +: 8];
            rknown[base+k] = 1;
          end
      end
      cw = mreq && mwe && !maddr[11] && off == 32'h40;
      end_now = (m_cnt == 1);
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      else if (cw)    m_cnt = 4;
      if (end_now) begin
        m_exec = 0; m_abort = 0; m_op = 0;
      end else if (req && !m_exec) begin
        m_exec = 1; m_abort = 0; m_op = int'(op); m_loc = int'(loc); m_size = int'(size);
      end else if (abrt && m_exec) begin
        m_abort = 1;
      end
    end
    exp_done = (m_cnt != 0);
    exp_irq  = m_exec && (m_cnt == 0);
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done === exp_done, "R6 done", 32'(done), 32'(exp_done));
      chk(irq === exp_irq, "R5 irq", 32'(irq), 32'(exp_irq));
      if (rd_pend) chk(mrdata === exp_rd, exp_tag, mrdata, exp_rd);
      if (fb_pend) chk(fb_rdata === exp_fb, "R10 byte port", 32'(fb_rdata), 32'(exp_fb));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic mcu_rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    mreq = 1; mwe = 0; maddr = a; rd_tag = tag;
    @(negedge clk);
    mreq = 0;
  endtask

  task automatic mcu_wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    mreq = 1; mwe = 1; maddr = a; mbe = be; mwdata = d;
    @(negedge clk);
    mreq = 0; mwe = 0;
  endtask

  task automatic fb_wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    fb_addr = a; fb_we = 1; fb_wdata = d;
    @(negedge clk);
    fb_we = 0;
  endtask

  task automatic fb_look(input logic [10:0] a);
    @(negedge clk);
    fb_addr = a;
    @(negedge clk);
  endtask

  task automatic fpga_req(input logic [3:0] o, input logic [3:0] l, input logic [11:0] s);
    @(negedge clk);
    req = 1; op = o; loc = l; size = s;
    @(negedge clk);
    req = 0;
  endtask

  task automatic fpga_abort();
    @(negedge clk);
    abrt = 1;
    @(negedge clk);
    abrt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mreq = 0; mwe = 0; mbe = 0; maddr = 0; mwdata = 0;
    req = 0; op = 0; loc = 0; size = 0; abrt = 0;
    fb_addr = 0; fb_we = 0; fb_wdata = 0;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk(done === 1'b0 && irq === 1'b0, "R1 reset outputs", {30'd0, done, irq}, 32'd0);
    mcu_rd(12'h000, "R1 status");
    mcu_rd(12'h004, "R1 op");
    mcu_rd(12'h010, "R2 unmapped");
    mcu_rd(12'h040, "R2 complete read");
    mcu_rd(12'h7FC, "R2 top of low half");

    // engine loads payload
    for (int i = 0; i < 16; i++) fb_wr(11'(i), 8'h10 + 8'(i));
    fb_wr(11'h7FC, 8'hE0); fb_wr(11'h7FD, 8'hE1); fb_wr(11'h7FE, 8'hE2); fb_wr(11'h7FF, 8'hE3);
    fb_look(11'd5);

    fpga_req(4'h1, 4'hF, 12'd16);
    idle(1);
    mcu_rd(12'h000, "R4 status");
    mcu_rd(12'h004, "R4 op");
    mcu_rd(12'h008, "R4 locality");
    mcu_rd(12'h00C, "R4 size");
    mcu_rd(12'h00B, "R11 low bits ignored");
    mcu_rd(12'h800, "R9 buffer word 0");
    mcu_rd(12'h80E, "R11 buffer low bits");
    mcu_rd(12'hFFC, "R9 buffer last word");

    mcu_wr(12'h800, 4'b0101, 32'hAABBCCDD);
    mcu_rd(12'h800, "R9 byte strobes");
    fb_look(11'd2);
    fb_look(11'd1);

    mcu_wr(12'h000, 4'hF, 32'hFFFF_FFFF);
    mcu_wr(12'h004, 4'hF, 32'h0000_0007);
    mcu_wr(12'h00C, 4'hF, 32'h0000_0123);
    mcu_rd(12'h000, "R3 status kept");
    mcu_rd(12'h004, "R3 op kept");
    mcu_rd(12'h00C, "R3 size kept");
    mcu_wr(12'h020, 4'hF, 32'h1234_5678);
    mcu_rd(12'h020, "R2 unmapped write dropped");

    fpga_req(4'h2, 4'h3, 12'd5);
    mcu_rd(12'h004, "R4 request ignored while busy");
    mcu_rd(12'h008, "R4 locality kept");

    fpga_abort();
    mcu_rd(12'h000, "R8 abort set");

    // same byte written from both sides in one cycle
    @(negedge clk);
    fb_addr = 11'd4; fb_we = 1; fb_wdata = 8'h55;
    mreq = 1; mwe = 1; maddr = 12'h804; mbe = 4'b0001; mwdata = 32'h0000_00A7;
    @(negedge clk);
    fb_we = 0; mreq = 0; mwe = 0;
    fb_look(11'd4);
    mcu_rd(12'h804, "R10 collision word");

    // completion, with a second write inside the pulse
    mcu_wr(12'h040, 4'hF, 32'hDEAD_0000);
    mcu_rd(12'h000, "R6 status during pulse");
    mcu_wr(12'h043, 4'h0, 32'h0);
    idle(4);
    mcu_rd(12'h004, "R7 op cleared");
    mcu_rd(12'h000, "R7 status cleared");
    mcu_rd(12'h008, "R7 locality kept");

    mcu_wr(12'h808, 4'hF, 32'h9999_9999);
    fb_look(11'd8);
    fb_look(11'd11);
    fpga_abort();
    mcu_rd(12'h000, "R8 abort ignored when idle");

    fpga_req(4'hC, 4'h2, 12'h7FF);
    idle(1);
    mcu_rd(12'h000, "R4 second status");
    mcu_rd(12'h004, "R4 second op");
    mcu_rd(12'h00C, "R4 second size");
    mcu_rd(12'h808, "R9 idle write dropped");
    fpga_abort();
    mcu_wr(12'h040, 4'h1, 32'h0);
    idle(6);
    mcu_rd(12'h000, "R7 abort cleared");
    idle(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule